// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector and Bank Aggregator

This block watches the synchronized input levels of a bank of general-purpose pins, grouped into ports of eight, and turns configured conditions on each pin into latched status bits. Every pin has its own trigger type: rising edge, falling edge, either edge, high level or low level. A latched status bit that is also enabled raises the single interrupt request of the whole bank. The request stays high as long as any such pin remains.

Software reaches the block through a simple register bus. Each port has four registers: trigger type, enable, status and a write-one-to-clear register. The type, enable and status registers also have masked-write aliases, so one pin can be changed without a read-modify-write. An edge that arrives after its status bit was cleared is always captured again. A level condition that is still present sets its bit again at once after a clear.

Top module: `gpio_irq_bank`

## Requirements
- R1: The trigger type of port p sits at address 0x060+4p and reads back as 24 bits. For pin n, bit n is the polarity (1 = high or rising), bit 8+n selects edge (1) or level (0), and bit 16+n selects both edges when edge is set. Per pin, shifted left by n: rising = 0x000101, falling = 0x000100, either edge = 0x010100, high = 0x000001, low = 0x000000. The type register resets to zero.
- R2: In rising or falling mode, the status bit sets at the clock edge where the sampled pin level differs from the previous sample in the selected direction. A change in the opposite direction, or no change, does not set it.
- R3: In either-edge mode, any change of the sampled level sets the status bit.
- R4: In a level mode, the status bit sets at every clock edge where the pin equals the polarity. Once the pin stops matching, a clear leaves the bit at 0.
- R5: Writing to 0x070+4p clears status bit n for every data bit n that is 1. Data bits that are 0 leave their status bits unchanged. The clear address reads as zero.
- R6: If a detected event and a clear of the same status bit fall on the same clock edge, the bit ends up set.
- R7: irq_o is high whenever some pin of some port has both its status bit and its enable bit set. It follows the registers with no added delay.
- R8: All enable registers reset to zero, and irq_o is low after reset.
- R9: The enable register of port p is at 0x050+4p. Its masked alias at 0x850+4p takes bits 15:8 as a pin mask and bits 7:0 as new values. Enable bits outside the mask keep their value.
- R10: The masked type alias at 0x860+4p takes bits 31:24 as a pin mask. For each masked pin n, bits n, 8+n and 16+n are loaded from the data. The lanes of unmasked pins keep their value.
- R11: Status of port p reads at 0x040+4p, and a plain write there has no effect. The masked alias at 0x840+4p loads the status bits selected by mask bits 15:8 with values from bits 7:0. An event on the same clock edge still sets its bit.
- R12: Bits 3:2 of the address select the port. Masked aliases and every address outside the map read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | 32 | Synchronized pin levels, pin n of port p at bit 8p+n |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 12 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read byte address |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The bench sweeps every pin of every port through all five trigger types. After each pin move it clears the bit and checks both the status word and the interrupt. A design with a swapped type lane or a wrong shift would then flag the wrong pin or the wrong direction. A design that dropped the re-assertion of a level condition would read zero after a clear while the level is still present. The bench also lands a clear and an edge on the same clock edge: a design that gives the clear priority loses the edge. Further tests write partial masks to the enable and status aliases and write to the read-only status address. Those catch decode errors that disturb bits outside the mask or let a plain write change status.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Register group selected by address bits 5:4 (with bit 6 set).
   typedef enum logic [1:0] {
      RK_STATUS = 2'd0,
      RK_ENABLE = 2'd1,
      RK_TYPE   = 2'd2,
      RK_CLEAR  = 2'd3
   } reg_kind_e;

   localparam int unsigned PORT_SEL_W = 2;   // address bits 3:2
   localparam int unsigned ALIAS_BIT  = 11;  // masked alias offset 0x800
   localparam int unsigned MAP_ADDR_W = 12;

   typedef struct packed {
      logic                  hit;
      logic                  masked;
      reg_kind_e             kind;
      logic [PORT_SEL_W-1:0] port;
   } reg_sel_t;

endpackage

// File: rtl/gpio_irq_regdec.sv
module gpio_irq_regdec
   import gpio_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_PORTS = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_t          sel_o
);

   logic upper_zero;
   logic port_ok;

   generate
      if (ADDR_W > MAP_ADDR_W) begin : g_wide
         assign upper_zero = (addr_i[ADDR_W-1:MAP_ADDR_W] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign port_ok = ({{(32-PORT_SEL_W){1'b0}}, addr_i[3:2]} < NUM_PORTS);

   always_comb begin
      sel_o        = '0;
      sel_o.masked = addr_i[ALIAS_BIT];
      sel_o.kind   = reg_kind_e'(addr_i[5:4]);
      sel_o.port   = addr_i[3:2];
      sel_o.hit    = upper_zero && port_ok && addr_i[6]
                     && (addr_i[10:7] == 4'd0) && (addr_i[1:0] == 2'd0)
                     && !(addr_i[ALIAS_BIT] && (reg_kind_e'(addr_i[5:4]) == RK_CLEAR));
   end

endmodule

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   input  logic pol_i,
   input  logic edge_i,
   input  logic both_i,
   input  logic clr_i,
   input  logic sw_wr_i,
   input  logic sw_val_i,
   output logic status_o
);

   logic prev_q;
   logic primed_q;
   logic status_q;
   logic rise_w;
   logic fall_w;
   logic hit_w;
   logic base_w;

   always_comb begin
      rise_w = primed_q & pin_i & ~prev_q;
      fall_w = primed_q & ~pin_i & prev_q;
      if (edge_i) begin
         if (both_i) hit_w = rise_w | fall_w;
         else        hit_w = pol_i ? rise_w : fall_w;
      end else begin
         hit_w = (pin_i == pol_i);
      end
      if (sw_wr_i)    base_w = sw_val_i;
      else if (clr_i) base_w = 1'b0;
      else            base_w = status_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q   <= 1'b0;
         primed_q <= 1'b0;
         status_q <= 1'b0;
      end else begin
         prev_q   <= pin_i;
         primed_q <= 1'b1;
         status_q <= base_w | hit_w;
      end
   end

   assign status_o = status_q;

   // R2: a configured rising edge always lands in status
   a_r2_rise_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i && !both_i && pol_i && primed_q && pin_i && !prev_q) |=> status_q);

   // R3: any change in either-edge mode lands in status
   a_r3_both_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i && both_i && primed_q && (pin_i != prev_q)) |=> status_q);

   // R4: a matching level keeps status set
   a_r4_level_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_i && (pin_i == pol_i)) |=> status_q);

   // R5: a clear with a steady pin in edge mode empties the bit
   a_r5_clear_drops : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !sw_wr_i && edge_i && (pin_i == prev_q)) |=> !status_q);

   // R6: a falling edge colliding with a clear still survives
   a_r6_edge_beats_clear : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && edge_i && !both_i && !pol_i && primed_q && !pin_i && prev_q) |=> status_q);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PINS   = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PINS-1:0]   pins_i,
   input  logic              wr_i,
   input  reg_kind_e         kind_i,
   input  logic              masked_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [PINS-1:0]   status_o,
   output logic [PINS-1:0]   enable_o,
   output logic [3*PINS-1:0] type_o
);

   logic [PINS-1:0] en_q;
   logic [PINS-1:0] pol_q;
   logic [PINS-1:0] edg_q;
   logic [PINS-1:0] both_q;

   logic [PINS-1:0] lo_val;    // values / polarity lane
   logic [PINS-1:0] mid_val;   // masked mask / edge lane
   logic [PINS-1:0] hi_val;    // both-edges lane
   logic [PINS-1:0] ty_mask;

   assign lo_val  = wdata_i[PINS-1:0];
   assign mid_val = wdata_i[2*PINS-1:PINS];
   assign hi_val  = wdata_i[3*PINS-1:2*PINS];
   assign ty_mask = wdata_i[4*PINS-1:3*PINS];

   logic wr_en_w;
   logic wr_ty_w;
   logic wr_clr_w;
   logic wr_st_w;

   assign wr_en_w  = wr_i && (kind_i == RK_ENABLE);
   assign wr_ty_w  = wr_i && (kind_i == RK_TYPE);
   assign wr_clr_w = wr_i && (kind_i == RK_CLEAR) && !masked_i;
   assign wr_st_w  = wr_i && (kind_i == RK_STATUS) && masked_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (wr_en_w) begin
         if (masked_i) en_q <= (en_q & ~mid_val) | (lo_val & mid_val);
         else          en_q <= lo_val;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pol_q  <= '0;
         edg_q  <= '0;
         both_q <= '0;
      end else if (wr_ty_w) begin
         if (masked_i) begin
            pol_q  <= (pol_q  & ~ty_mask) | (lo_val  & ty_mask);
            edg_q  <= (edg_q  & ~ty_mask) | (mid_val & ty_mask);
            both_q <= (both_q & ~ty_mask) | (hi_val  & ty_mask);
         end else begin
            pol_q  <= lo_val;
            edg_q  <= mid_val;
            both_q <= hi_val;
         end
      end
   end

   generate
      for (genvar n = 0; n < PINS; n++) begin : g_pin
         gpio_irq_pin_det u_det (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .pin_i    (pins_i[n]),
            .pol_i    (pol_q[n]),
            .edge_i   (edg_q[n]),
            .both_i   (both_q[n]),
            .clr_i    (wr_clr_w && lo_val[n]),
            .sw_wr_i  (wr_st_w && mid_val[n]),
            .sw_val_i (lo_val[n]),
            .status_o (status_o[n])
         );
      end
   endgenerate

   assign enable_o = en_q;
   assign type_o   = {both_q, edg_q, pol_q};

   // R9: masked enable write leaves unmasked bits alone
   a_r9_masked_keeps : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_w && masked_i) |=> ((en_q & ~$past(mid_val)) == ($past(en_q) & ~$past(mid_val))));

   // R10: masked type write leaves lanes of unmasked pins alone
   a_r10_type_keeps : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ty_w && masked_i) |=> ((edg_q & ~$past(ty_mask)) == ($past(edg_q) & ~$past(ty_mask))));

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0] status_i,
   input  logic [N-1:0] enable_i,
   output logic         irq_o
);

   assign irq_o = |(status_i & enable_i);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PORT_PINS = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 12
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_PORTS*PORT_PINS-1:0] pin_lvl_i,
   input  logic                           wr_en_i,
   input  logic [ADDR_W-1:0]              wr_addr_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   input  logic [ADDR_W-1:0]              rd_addr_i,
   output logic [DATA_W-1:0]              rd_data_o,
   output logic                           irq_o
);

   localparam int unsigned NPINS  = NUM_PORTS * PORT_PINS;
   localparam int unsigned TYPE_W = 3 * PORT_PINS;

   generate
      if (PORT_PINS < 1 || 4 * PORT_PINS > DATA_W) begin : g_bad_pins
         $error("PORT_PINS must fit four lanes in DATA_W");
      end
      if (NUM_PORTS < 1 || NUM_PORTS > (1 << PORT_SEL_W)) begin : g_bad_ports
         $error("NUM_PORTS exceeds the port select field");
      end
      if (ADDR_W < MAP_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   reg_sel_t wsel;
   reg_sel_t rsel;

   gpio_irq_regdec #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_wdec (
      .addr_i (wr_addr_i),
      .sel_o  (wsel)
   );

   gpio_irq_regdec #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_rdec (
      .addr_i (rd_addr_i),
      .sel_o  (rsel)
   );

   logic [NUM_PORTS-1:0][PORT_PINS-1:0] stat_w;
   logic [NUM_PORTS-1:0][PORT_PINS-1:0] en_w;
   logic [NUM_PORTS-1:0][TYPE_W-1:0]    type_w;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         logic port_wr;
         assign port_wr = wr_en_i && wsel.hit && (wsel.port == PORT_SEL_W'(p));

         gpio_irq_port #(.PINS(PORT_PINS), .DATA_W(DATA_W)) u_port (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .pins_i   (pin_lvl_i[p*PORT_PINS +: PORT_PINS]),
            .wr_i     (port_wr),
            .kind_i   (wsel.kind),
            .masked_i (wsel.masked),
            .wdata_i  (wr_data_i),
            .status_o (stat_w[p]),
            .enable_o (en_w[p]),
            .type_o   (type_w[p])
         );
      end
   endgenerate

   gpio_irq_agg #(.N(NPINS)) u_agg (
      .status_i (stat_w),
      .enable_i (en_w),
      .irq_o    (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (rsel.hit && !rsel.masked) begin
         case (rsel.kind)
            RK_STATUS: rd_data_o = DATA_W'(stat_w[rsel.port]);
            RK_ENABLE: rd_data_o = DATA_W'(en_w[rsel.port]);
            RK_TYPE:   rd_data_o = DATA_W'(type_w[rsel.port]);
            default:   rd_data_o = '0;
         endcase
      end
   end

   // R8: with every enable at zero the request stays low
   a_r8_quiet_when_disabled : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_w == '0) |-> !irq_o);

   // R7: request high implies some port holds an enabled bit
   a_r7_irq_has_source : assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (en_w != '0) && (stat_w != '0));

endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;

   localparam int NP = 4;
   localparam int PP = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] pins;
   logic        wr_en;
   logic [11:0] wr_addr;
   logic [31:0] wr_data;
   logic [11:0] rd_addr;
   logic [31:0] rd_data;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   gpio_irq_bank u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .pin_lvl_i (pins),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Called just after a falling edge; spans exactly one rising edge.
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [31:0] enc(input int m);
      case (m)
         0:       return 32'h000101;
         1:       return 32'h000100;
         2:       return 32'h010100;
         3:       return 32'h000001;
         default: return 32'h000000;
      endcase
   endfunction

   function automatic bit ev(input int m, input bit p, input bit c);
      case (m)
         0:       return !p && c;
         1:       return p && !c;
         2:       return p != c;
         3:       return c;
         default: return !c;
      endcase
   endfunction

   function automatic string mreq(input int m);
      if (m < 2) return "R2";
      if (m == 2) return "R3";
      return "R4";
   endfunction

   initial begin
      #800000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      bit seq [6];
      seq = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
      rst_n = 1'b0; pins = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state: R8 enables zero, R1 types zero
      for (int p = 0; p < NP; p++) begin
         rd(12'h050 + 12'(4*p), d); chk("R8 enable reset", d, 32'h0);
         rd(12'h060 + 12'(4*p), d); chk("R1 type reset", d, 32'h0);
      end
      chk("R8 irq after reset", {31'b0, irq}, 32'h0);
      @(negedge clk);

      // Sweep: every port, every pin, every trigger type
      for (int p = 0; p < NP; p++) begin
         for (int n = 0; n < PP; n++) begin
            for (int m = 0; m < 5; m++) begin
               int idx;
               bit st;
               bit prev;
               logic [11:0] po;
               idx = p*PP + n;
               po  = 12'(4*p);
               wr(12'h060 + po, 32'h00FFFF);
               wr(12'h050 + po, 32'h1 << n);
               wr(12'h860 + po, (32'h1 << (24+n)) | (enc(m) << n));
               rd(12'h060 + po, d);
               chk("R10 R1 masked type readback", d,
                   (32'h00FFFF & ~(32'h010101 << n)) | (enc(m) << n));
               @(negedge clk);
               prev = 1'b0;
               wr(12'h070 + po, 32'hFF);
               st = ev(m, prev, prev);
               rd(12'h040 + po, d);
               chk("R5 status after clear", d, 32'(st) << n);
               chk("R7 irq after clear", {31'b0, irq}, {31'b0, st});
               @(negedge clk);
               for (int k = 0; k < 6; k++) begin
                  pins[idx] = seq[k];
                  @(negedge clk);
                  st = st | ev(m, prev, seq[k]);
                  prev = seq[k];
                  rd(12'h040 + po, d);
                  chk(mreq(m), d, 32'(st) << n);
                  chk("R7 irq follows status", {31'b0, irq}, {31'b0, st});
                  @(negedge clk);
                  st = st | ev(m, prev, prev);
                  wr(12'h070 + po, 32'h1 << n);
                  st = ev(m, prev, prev);
                  rd(12'h040 + po, d);
                  chk("R5 R4 status after pin clear", d, 32'(st) << n);
                  @(negedge clk);
               end
               wr(12'h050 + po, 32'h0);
            end
         end
      end

      for (int p = 0; p < NP; p++) begin
         wr(12'h060 + 12'(4*p), 32'h00FFFF);
         wr(12'h070 + 12'(4*p), 32'hFF);
      end

      // R6: rising edge on port 1 pin 2 together with its clear
      pins[10] = 1'b1;
      wr(12'h074, 32'h04);
      rd(12'h044, d); chk("R6 edge beats clear", d, 32'h04);
      @(negedge clk);

      // R5: zero data bits leave other status bits alone
      pins[11] = 1'b1;
      @(negedge clk);
      rd(12'h044, d); chk("R2 second edge", d, 32'h0C);
      @(negedge clk);
      wr(12'h074, 32'h08);
      rd(12'h044, d); chk("R5 partial clear", d, 32'h04);
      rd(12'h074, d); chk("R5 clear reads zero", d, 32'h0);
      @(negedge clk);

      // R11: plain status write ignored, masked alias sets and clears
      wr(12'h044, 32'h0);
      rd(12'h044, d); chk("R11 plain status write ignored", d, 32'h04);
      @(negedge clk);
      wr(12'h844, 32'h0101);
      rd(12'h044, d); chk("R11 masked status set", d, 32'h05);
      @(negedge clk);
      wr(12'h844, 32'h0400);
      rd(12'h044, d); chk("R11 masked status clear", d, 32'h01);
      @(negedge clk);

      // R9 and R7 on port 2
      wr(12'h078, 32'hFF);
      wr(12'h058, 32'hAA);
      wr(12'h858, 32'h0F05);
      rd(12'h058, d); chk("R9 masked enable", d, 32'hA5);
      chk("R7 no irq without status", {31'b0, irq}, 32'h0);
      @(negedge clk);
      wr(12'h848, 32'h0101);
      chk("R7 irq from port 2", {31'b0, irq}, 32'h1);
      @(negedge clk);
      wr(12'h058, 32'h0);
      rd(12'h048, d); chk("R7 status kept after disable", d, 32'h01);
      chk("R7 irq drops with enable", {31'b0, irq}, 32'h0);

      // R12: aliases and unmapped addresses read zero; port decode
      rd(12'h840, d); chk("R12 alias reads zero", d, 32'h0);
      rd(12'h0C0, d); chk("R12 unmapped reads zero", d, 32'h0);
      rd(12'h080, d); chk("R12 unmapped reads zero", d, 32'h0);
      rd(12'h064, d); chk("R12 port 1 type", d, 32'h00FFFF);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule